// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous requester and an external asynchronous static RAM of 131,072 bytes, which is addressed by 17 lines. The requester raises a one-cycle request together with a write flag, an address and, for writes, a data byte. The block then drives the RAM's address, its two select lines of opposite polarity, its write and output strobes, and a split data bus with a driver enable for the tri-state pad. Every strobe phase lasts a whole number of clock cycles. That number is computed from a clock-period parameter and a speed-grade parameter, so the same code can drive the fast part or the slow part at any clock rate.

While an access is in progress the block drops ready and ignores any further request. Between accesses it deselects the RAM, which lets the device fall into standby with its data pins floating. A read returns its byte together with a single-cycle valid pulse. A write that follows a read is held back until the RAM has had enough time to release the shared data pins. The block's own driver is switched on only after that wait and is switched off one cycle after the write strobe ends, so the two drivers never overlap.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, ready is 1, valid is 0, the active-low select is 1, the active-high select is 0, the write and output strobes are both 1, and the data driver enable is 0.
- R2: Whenever ready is 1, the RAM is deselected (active-low select 1, active-high select 0), the write strobe is 1, the output strobe is 1 and the driver is off.
- R3: A read holds the active-low select at 0, the active-high select at 1, the output strobe at 0 and the write strobe at 1 for exactly N_ACC cycles. N_ACC = ceil(T_ACC / CLK_PERIOD_NS), with T_ACC = 55 ns for SPEED_GRADE 0 and 70 ns for SPEED_GRADE 1. With the defaults (5 ns clock, grade 0), N_ACC is 11.
- R4: The read byte is taken from the RAM data input in the last cycle of the read. It appears on the read-data output with a one-cycle valid pulse, N_ACC rising edges after the edge that accepted the request. Ready returns in the same cycle as the pulse.
- R5: During a write, the write strobe is 0 for exactly N_ACC cycles. Throughout that time both selects are active, the output strobe is 1, the driver enable is 1 and the data output carries the accepted write byte, so the byte is stored at the accepted address.
- R6: In the cycle after the write strobe returns to 1, the driver enable is still 1 and the RAM is already deselected. In the cycle after that, the driver enable is 0.
- R7: The driver enable never rises unless at least N_TA cycles with the output strobe at 1 have passed since it was last 0. N_TA = ceil(30 / CLK_PERIOD_NS), which is 6 with the defaults. A write accepted in the first ready cycle after a read sees exactly N_TA such cycles, and its ready returns N_ACC + N_TA edges after acceptance.
- R8: The driver enable is never 1 in a cycle where the output strobe is 0.
- R9: A request made while ready is 0 is ignored: it starts no access and changes no stored byte.
- R10: While the active-low select is 0, the RAM address is stable and equal to the address that was accepted.
- R11: Ready is 0 throughout every access. A write with no pending turnaround returns ready N_ACC + 1 edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Access request, taken when ready is 1 |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 8 | Byte to write |
| ready_o | output | 1 | Idle and able to accept a request |
| rdata_o | output | 8 | Byte returned by the last read |
| rvalid_o | output | 1 | One-cycle pulse when rdata_o is new |
| mem_addr_o | output | 17 | RAM address lines |
| mem_ce_n_o | output | 1 | RAM select, active low |
| mem_ce2_o | output | 1 | RAM select, active high |
| mem_we_n_o | output | 1 | RAM write strobe, active low |
| mem_oe_n_o | output | 1 | RAM output strobe, active low |
| mem_dq_o | output | 8 | Data toward the RAM pads |
| mem_dq_i | input | 8 | Data from the RAM pads |
| mem_dq_oe_o | output | 1 | Pad driver enable for mem_dq_o |

## Verification
Read data and its valid pulse are due N_ACC edges after the accepting edge. A write's ready is due N_ACC + 1 edges after acceptance, or N_ACC + N_TA edges when the write directly follows a read. The bench counts rising edges from the accepting edge and samples every result just after the falling edge that follows. It compares the count with these exact numbers and does not merely wait for the event. A RAM model that returns garbage until a read has lasted N_ACC cycles, and that stores a byte only after a full-width write pulse with the driver on, exposes any strobe phase that is cut short. Pulse lengths, the turnaround gap and driver overlap are measured cycle by cycle, at the same half-cycle sampling point.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WR,
    ST_REL
  } seq_st_e;

  // Registered pin image toward the RAM.
  typedef struct packed {
    logic ce_n;
    logic ce2;
    logic we_n;
    logic oe_n;
    logic drv;
  } pins_t;

  // Worst-case time for the RAM to stop driving its data pins.
  localparam int unsigned FLOAT_NS = 30;

  function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned access_ns(input int unsigned grade);
    return (grade == 0) ? 55 : 70;
  endfunction

  function automatic pins_t pins_of(input seq_st_e st);
    pins_t p;
    case (st)
      ST_RD:   p = '{ce_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
      ST_WR:   p = '{ce_n: 1'b0, ce2: 1'b1, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
      ST_REL:  p = '{ce_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      default: p = '{ce_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
// Down-counter that times one strobe phase; last_o marks its final cycle.
module sram_seq_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = load_val_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_quiet.sv
// Counts cycles since the RAM last drove the bus (saturating at LIMIT).
// ok_o means the next cycle will have LIMIT quiet cycles behind it.
module sram_seq_quiet #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reading_i,
  output logic ok_o
);
  localparam int unsigned QW = $clog2(LIMIT + 1);

  logic [QW-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (reading_i)               q_d = '0;
    else if (q_q != QW'(LIMIT))  q_d = q_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= QW'(LIMIT);
    else        q_q <= q_d;
  end

  assign ok_o = (q_q >= QW'(LIMIT - 1));
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce2_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int unsigned N_ACC  = cyc_of(access_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int unsigned N_TA   = cyc_of(FLOAT_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_W  = (N_ACC > 1) ? $clog2(N_ACC) : 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(N_ACC - 1);

  seq_st_e           st_q, st_d;
  pins_t             pins_q, pins_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q, rvalid_d;
  logic              acc_en, cap_en, tmr_load, tmr_last, turn_ok;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (LOAD_V),
    .last_o     (tmr_last)
  );

  sram_seq_quiet #(.LIMIT(N_TA)) u_quiet (
    .clk       (clk),
    .rst_n     (rst_n),
    .reading_i (st_q == ST_RD),
    .ok_o      (turn_ok)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    acc_en = 1'b0;
    cap_en = 1'b0;
    case (st_q)
      ST_IDLE: if (req_i) begin
        acc_en = 1'b1;
        if (!wr_i)        st_d = ST_RD;
        else if (turn_ok) st_d = ST_WR;
        else              st_d = ST_TURN;
      end
      ST_RD:   if (tmr_last) begin
        cap_en = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_TURN: if (turn_ok)  st_d = ST_WR;
      ST_WR:   if (tmr_last) st_d = ST_REL;
      ST_REL:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    tmr_load = (st_d != st_q) && ((st_d == ST_RD) || (st_d == ST_WR));
    pins_d   = pins_of(st_d);
    rvalid_d = cap_en;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pins_q   <= pins_of(ST_IDLE);
      rvalid_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      st_q     <= st_d;
      pins_q   <= pins_d;
      rvalid_q <= rvalid_d;
      if (acc_en) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (cap_en) rdata_q <= mem_dq_i;
    end
  end

  assign ready_o     = (st_q == ST_IDLE);
  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;
  assign mem_addr_o  = addr_q;
  assign mem_ce_n_o  = pins_q.ce_n;
  assign mem_ce2_o   = pins_q.ce2;
  assign mem_we_n_o  = pins_q.we_n;
  assign mem_oe_n_o  = pins_q.oe_n;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = pins_q.drv;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
  import sram_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int unsigned ADDR_W        = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_n_o,
  input logic              mem_ce2_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_dq_oe_o
);
  localparam int unsigned N_ACC = cyc_of(access_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int unsigned N_TA  = cyc_of(FLOAT_NS, CLK_PERIOD_NS);

  int unsigned we_run, oe_run, oe_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= 0;
      oe_run <= 0;
      oe_hi  <= N_TA;
    end else begin
      we_run <= mem_we_n_o ? 0 : we_run + 1;
      oe_run <= mem_oe_n_o ? 0 : oe_run + 1;
      if (!mem_oe_n_o)      oe_hi <= 0;
      else if (oe_hi < N_TA) oe_hi <= oe_hi + 1;
    end
  end

  a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (mem_ce_n_o && !mem_ce2_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

  a_r3_read_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n_o) |-> (oe_run == N_ACC));

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> !rvalid_o);

  a_r5_write_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> (!mem_ce_n_o && mem_ce2_o && mem_oe_n_o && mem_dq_oe_o));

  a_r5_write_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> (we_run == N_ACC));

  a_r6_release_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> (mem_dq_oe_o && mem_ce_n_o));

  a_r6_release_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |=> !mem_dq_oe_o);

  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe_o) |-> (oe_hi >= N_TA));

  a_r8_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe_o && !mem_oe_n_o));

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o));

  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n_o |-> !ready_o);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .SPEED_GRADE   (SPEED_GRADE),
  .ADDR_W        (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_ce2_o   (mem_ce2_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;
  localparam int CLK_NS = 5;
  localparam int N_ACC  = (55 + CLK_NS - 1) / CLK_NS;
  localparam int N_TA   = (30 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ready, rvalid, ce_n, ce2, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [16:0] addr_o;

  always #2.5 clk = ~clk;

  sram_seq_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(0)) u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid), .mem_addr_o(addr_o),
    .mem_ce_n_o(ce_n), .mem_ce2_o(ce2), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_dq_o(dq_o), .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  // RAM model: garbage until a read has lasted N_ACC cycles; stores only full-width pulses.
  logic [7:0] ram [64];
  int rcnt = 0, wrun = 0;
  logic wok = 1'b0;
  logic [7:0] wlat = '0;
  logic [5:0] wadr = '0;
  wire sel = !ce_n && ce2;
  assign dq_i = (sel && we_n && !oe_n && rcnt >= N_ACC - 1) ? ram[addr_o[5:0]] : 8'hEE;

  always @(posedge clk) begin
    rcnt <= (sel && we_n && !oe_n) ? rcnt + 1 : 0;
    if (sel && !we_n) begin
      wrun <= wrun + 1;
      wlat <= dq_o;
      wadr <= addr_o[5:0];
      wok  <= (wrun == 0) ? dq_oe : (wok && dq_oe);
    end else if (wrun != 0) begin
      if (wrun >= N_ACC && wok) ram[wadr] <= wlat;
      wrun <= 0;
    end
  end

  // Pin monitors, sampled in the middle of each cycle.
  int contention = 0, gap = N_TA, last_gap = -1, min_gap = 1000;
  int oe_run = 0, last_oe_run = 0, we_run = 0, last_we_run = 0;
  int rel_bad = 0, rel_seen = 0, addr_bad = 0, sel_starts = 0;
  logic dq_oe_p = 1'b0, we_n_p = 1'b1, oe_n_p = 1'b1, ce_n_p = 1'b1, rel_follow = 1'b0;
  logic [16:0] sel_addr = '0;

  always @(negedge clk) if (rst_n) begin
    if (dq_oe && !oe_n) contention <= contention + 1;
    if (!oe_n) gap <= 0; else if (gap < 1000) gap <= gap + 1;
    if (dq_oe && !dq_oe_p) begin
      last_gap <= gap;
      if (gap < min_gap) min_gap <= gap;
    end
    if (!oe_n) oe_run <= oe_run + 1;
    else begin
      if (!oe_n_p) last_oe_run <= oe_run;
      oe_run <= 0;
    end
    if (!we_n) we_run <= we_run + 1;
    else begin
      if (!we_n_p) last_we_run <= we_run;
      we_run <= 0;
    end
    if (we_n && !we_n_p) begin
      rel_seen <= rel_seen + 1;
      if (!(dq_oe && ce_n)) rel_bad <= rel_bad + 1;
      rel_follow <= 1'b1;
    end else begin
      rel_follow <= 1'b0;
    end
    if (rel_follow && dq_oe) rel_bad <= rel_bad + 1;
    if (!ce_n && ce_n_p) begin
      sel_starts <= sel_starts + 1;
      sel_addr   <= addr_o;
    end else if (!ce_n && addr_o != sel_addr) begin
      addr_bad <= addr_bad + 1;
    end
    dq_oe_p <= dq_oe; we_n_p <= we_n; oe_n_p <= oe_n; ce_n_p <= ce_n;
  end

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  // Called and returns at falling edge + 1 ns; lat = rising edges after the accepting edge.
  task automatic access(input bit w, input logic [16:0] a, input logic [7:0] d,
                        output logic [7:0] got, output int lat);
    int guard = 0;
    while (!ready && guard < 300) begin
      @(negedge clk); #1; guard++;
    end
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); #1;
    req = 1'b0; wr = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); @(negedge clk); #1;
      lat++;
    end while (!(w ? ready : rvalid) && lat < 300);
    got = rdata;
  endtask

  // {write flag, address, data or expected byte}
  localparam logic [25:0] VEC [8] = '{
    {1'b1, 17'h00000, 8'h3C},
    {1'b1, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h00015, 8'h5A},
    {1'b0, 17'h00000, 8'h3C},
    {1'b0, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h00015, 8'h99},
    {1'b0, 17'h00015, 8'h99},
    {1'b0, 17'h00000, 8'h3C}
  };

  initial begin
    logic [7:0] got;
    int lat, starts0;
    bit prev_rd;

    repeat (3) @(negedge clk);
    // R1 while in reset
    chk(ready == 1'b1, "R1 ready in reset", ready, 1);
    chk(rvalid == 1'b0, "R1 valid in reset", rvalid, 0);
    chk(ce_n == 1'b1 && ce2 == 1'b0, "R1 deselect in reset", {ce_n, ce2}, 2'b10);
    chk(we_n && oe_n, "R1 strobes in reset", {we_n, oe_n}, 2'b11);
    chk(dq_oe == 1'b0, "R1 driver in reset", dq_oe, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ready && ce_n && !ce2 && we_n && oe_n && !dq_oe && !rvalid, "R1 after reset",
        {ready, ce_n, ce2, we_n, oe_n, dq_oe, rvalid}, 7'b1101100);

    prev_rd = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bit w;
      w = VEC[i][25];
      access(w, VEC[i][24:8], VEC[i][7:0], got, lat);
      if (w) begin
        if (prev_rd) chk(lat == N_ACC + N_TA, "R7 write latency after read", lat, N_ACC + N_TA);
        else         chk(lat == N_ACC + 1, "R11 write latency", lat, N_ACC + 1);
        chk(last_we_run == N_ACC, "R5 write pulse width", last_we_run, N_ACC);
        if (prev_rd) chk(last_gap == N_TA, "R7 turnaround gap", last_gap, N_TA);
      end else begin
        chk(got == VEC[i][7:0], "R4 read data", got, VEC[i][7:0]);
        chk(lat == N_ACC, "R4 read latency", lat, N_ACC);
        chk(last_oe_run == N_ACC, "R3 read strobe width", last_oe_run, N_ACC);
      end
      prev_rd = !w;
    end

    // R9: requests while busy are ignored
    starts0 = sel_starts;
    req = 1'b1; wr = 1'b1; addr = 17'h00015; wdata = 8'h11;
    @(posedge clk); @(negedge clk); #1;
    chk(ready == 1'b0, "R11 ready low while busy", ready, 0);
    addr = 17'h00000; wdata = 8'hFF;
    repeat (8) begin @(posedge clk); @(negedge clk); #1; end
    req = 1'b0; wr = 1'b0;
    while (!ready) begin @(negedge clk); #1; end
    chk(sel_starts - starts0 == 1, "R9 single access while busy", sel_starts - starts0, 1);
    access(1'b0, 17'h00000, 8'h00, got, lat);
    chk(got == 8'h3C, "R9 ignored write left byte", got, 8'h3C);
    access(1'b0, 17'h00015, 8'h00, got, lat);
    chk(got == 8'h11, "R5 accepted write stored", got, 8'h11);

    // Bus-level bookkeeping
    chk(contention == 0, "R8 driver overlap", contention, 0);
    chk(min_gap >= N_TA, "R7 minimum turnaround", min_gap, N_TA);
    chk(rel_bad == 0 && rel_seen > 0, "R6 driver release", rel_bad, 0);
    chk(addr_bad == 0, "R10 address stable", addr_bad, 0);
    @(negedge clk); #1;
    chk(ready && ce_n && !ce2 && we_n && oe_n && !dq_oe, "R2 idle deselect",
        {ready, ce_n, ce2, we_n, oe_n, dq_oe}, 6'b110110);
    finish_run();
  end
endmodule